// File: doc/BRIEF.md
# Boot Reset Generator with Cause Capture

This block merges every wake and reset request of the chip into one active-high global reset. Any request that is present holds the reset asserted. Once the last request has gone, the reset stays asserted for a parameterised number of extra clock cycles and is then released on a clock edge. A supply-good flag acts as the power-on source: while it is low the reset is forced on at once, without waiting for a clock edge, and the cause is forced to the power-on code.

Each request source has a fixed five-bit cause code. When the reset rises from low to high, the block latches the code of the source that started it. The latched value stays on the cause output through the whole reset and after it, until the next rising edge of the reset. Most sources are active-high levels. The two temperature-error inputs request only on a falling edge. The PVDD-good flag and the current-limit flag request while they are low.

Top module: `boot_reset_gen`

## Requirements
- R1: While `pwr_ok_i` is 0, `rst_o` is 1 and `cause_o` is 0, with no clock edge needed.
- R2: Any request sampled at a rising clock edge makes `rst_o` 1 from that edge on.
- R3: After the last clock edge that samples a request (or a low `pwr_ok_i`), `rst_o` stays 1 for exactly STRETCH more edges. It then goes to 0 on the following edge.
- R4: Level request bits `lvl_req_i[0..12]` map, in bit order, to cause codes 1, 2, 3, 4, 5, 7, 8, 9, 10, 11, 12, 17 and 18.
- R5: `temp_err_i[0]` and `temp_err_i[1]` request only when an edge samples 0 and the previous edge sampled 1, giving codes 13 and 14. A rising edge, a steady 1 or a steady 0 on these inputs leaves `rst_o` at 0.
- R6: `pvdd_ok_i` at 0 requests with code 15. `ilim_ok_i` at 0 requests with code 16. Both are level sensitive.
- R7: When several requests are sampled at the edge that raises `rst_o`, `cause_o` takes the lowest of their codes.
- R8: `cause_o` changes only on the edge where `rst_o` goes from 0 to 1. A request that arrives while `rst_o` is already 1 extends the reset but leaves `cause_o` unchanged.
- R9: `cause_o` is never 6 and never above 18.
- R10: After power-on, `cause_o` stays 0 until a later request raises `rst_o` again from 0, even if other requests were present during power-on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| pwr_ok_i | input | 1 | Supply good; 0 is the power-on request and clears the block at once |
| lvl_req_i | input | 13 | Active-high level requests (code mapping in R4) |
| temp_err_i | input | 2 | Temperature error flags; a falling edge requests |
| pvdd_ok_i | input | 1 | PVDD present; 0 requests |
| ilim_ok_i | input | 1 | Current-limit flag; 0 requests |
| rst_o | output | 1 | Global reset, active high |
| cause_o | output | 5 | Code of the source that started the latest reset |

## Verification
A stretch counter that loaded or decremented wrongly would show as `rst_o` falling one or more cycles early or late, on the first release after the fault. A wrong priority or capture condition shows on `cause_o` in the cycle right after `rst_o` rises, or as a change in the middle of a reset. A stale edge-detect flop shows as a reset that appears, or fails to appear, one cycle after a temperature-input transition. The reference model is compared with both outputs on every cycle, so each of these faults shows at the ports within a few cycles of its cause.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

    localparam int CODE_W    = 5;
    localparam int NUM_CODES = 19;
    localparam int N_LVL     = 13;
    localparam int N_TEMP    = 2;

    typedef logic [CODE_W-1:0] cause_t;

    localparam cause_t C_POWER_ON = 5'd0;
    localparam cause_t C_RESERVED = 5'd6;
    localparam cause_t C_TEMP0    = 5'd13;
    localparam cause_t C_PVDD     = 5'd15;
    localparam cause_t C_ILIM     = 5'd16;

    // cause code for level request bit idx
    function automatic int lvl_code(input int idx);
        int c;
        if (idx < 5)       c = idx + 1;
        else if (idx < 11) c = idx + 2;
        else               c = idx + 6;
        return c;
    endfunction

endpackage

// File: rtl/rstgen_cond.sv
module rstgen_cond
    import rstgen_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 por_ni,
    input  logic [N_LVL-1:0]     lvl_req_i,
    input  logic [N_TEMP-1:0]    temp_err_i,
    input  logic                 pvdd_ok_i,
    input  logic                 ilim_ok_i,
    output logic [NUM_CODES-1:0] req_o
);

    typedef struct packed {
        logic [N_TEMP-1:0] temp_prev;
    } cond_state_t;

    cond_state_t st_d, st_q;
    logic [N_TEMP-1:0] temp_fall;

    always_comb begin
        st_d           = st_q;
        temp_fall      = st_q.temp_prev & ~temp_err_i;
        st_d.temp_prev = temp_err_i;
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // power-on is handled asynchronously; reserved code never requests
    assign req_o[C_POWER_ON] = 1'b0;
    assign req_o[C_RESERVED] = 1'b0;
    assign req_o[C_PVDD]     = ~pvdd_ok_i;
    assign req_o[C_ILIM]     = ~ilim_ok_i;

    for (genvar gi = 0; gi < N_LVL; gi++) begin : g_lvl
        assign req_o[lvl_code(gi)] = lvl_req_i[gi];
    end

    for (genvar gt = 0; gt < N_TEMP; gt++) begin : g_temp
        assign req_o[int'(C_TEMP0) + gt] = temp_fall[gt];
    end

endmodule

// File: rtl/rstgen_prio.sv
module rstgen_prio #(
    parameter int N = 19,
    parameter int W = 5
) (
    input  logic [N-1:0] req_i,
    output logic         any_o,
    output logic [W-1:0] code_o
);

    always_comb begin
        any_o  = |req_i;
        code_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) code_o = W'(i);
        end
    end

endmodule

// File: rtl/rstgen_stretch.sv
module rstgen_stretch #(
    parameter int STRETCH = 4,
    localparam int CNT_W  = $clog2(STRETCH + 1)
) (
    input  logic clk_i,
    input  logic por_ni,
    input  logic act_i,
    output logic rst_o,
    output logic start_o
);

    typedef struct packed {
        logic             rst;
        logic [CNT_W-1:0] cnt;
    } str_state_t;

    localparam str_state_t ST_RESET = '{rst: 1'b1, cnt: CNT_W'(STRETCH)};

    str_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        start_o = act_i & ~st_q.rst;
        if (act_i) begin
            st_d.rst = 1'b1;
            st_d.cnt = CNT_W'(STRETCH);
        end else if (st_q.cnt != '0) begin
            st_d.rst = 1'b1;
            st_d.cnt = st_q.cnt - 1'b1;
        end else begin
            st_d.rst = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) st_q <= ST_RESET;
        else         st_q <= st_d;
    end

    assign rst_o = st_q.rst;

endmodule

// File: rtl/boot_reset_gen.sv
module boot_reset_gen
    import rstgen_pkg::*;
#(
    parameter int STRETCH = 4
) (
    input  logic              clk_i,
    input  logic              pwr_ok_i,
    input  logic [N_LVL-1:0]  lvl_req_i,
    input  logic [N_TEMP-1:0] temp_err_i,
    input  logic              pvdd_ok_i,
    input  logic              ilim_ok_i,
    output logic              rst_o,
    output logic [CODE_W-1:0] cause_o
);

    typedef struct packed {
        cause_t cause;
    } top_state_t;

    logic [NUM_CODES-1:0] req;
    logic                 any_req;
    cause_t               win_code;
    logic                 start;
    top_state_t           st_d, st_q;

    rstgen_cond u_cond (
        .clk_i      (clk_i),
        .por_ni     (pwr_ok_i),
        .lvl_req_i  (lvl_req_i),
        .temp_err_i (temp_err_i),
        .pvdd_ok_i  (pvdd_ok_i),
        .ilim_ok_i  (ilim_ok_i),
        .req_o      (req)
    );

    rstgen_prio #(.N(NUM_CODES), .W(CODE_W)) u_prio (
        .req_i  (req),
        .any_o  (any_req),
        .code_o (win_code)
    );

    rstgen_stretch #(.STRETCH(STRETCH)) u_stretch (
        .clk_i   (clk_i),
        .por_ni  (pwr_ok_i),
        .act_i   (any_req),
        .rst_o   (rst_o),
        .start_o (start)
    );

    always_comb begin
        st_d = st_q;
        if (start) st_d.cause = win_code;
    end

    always_ff @(posedge clk_i or negedge pwr_ok_i) begin
        if (!pwr_ok_i) st_q <= '{cause: C_POWER_ON};
        else           st_q <= st_d;
    end

    assign cause_o = st_q.cause;

endmodule

// File: rtl/rstgen_chk.sv
module rstgen_chk (
    input logic        clk_i,
    input logic        pwr_ok_i,
    input logic [12:0] lvl_req_i,
    input logic [1:0]  temp_err_i,
    input logic        pvdd_ok_i,
    input logic        ilim_ok_i,
    input logic        rst_o,
    input logic [4:0]  cause_o
);

    // R1: power-on forces reset and code 0
    always @(negedge clk_i) begin
        if (!pwr_ok_i) begin
            p_por_forces_r1: assert (rst_o == 1'b1 && cause_o == 5'd0);
        end
    end

    p_level_holds_r2: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
        (|lvl_req_i) |=> rst_o);

    p_release_quiet_r3: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
        $fell(rst_o) |-> ($past(lvl_req_i) == 13'd0 && $past(ilim_ok_i) && $past(pvdd_ok_i)));

    p_temp_fall_r5: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
        ($past(pwr_ok_i) && $past(temp_err_i[0]) && !temp_err_i[0]) |=> rst_o);

    p_ilim_low_r6: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
        (!ilim_ok_i || !pvdd_ok_i) |=> rst_o);

    p_cause_held_r8: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
        rst_o |=> $stable(cause_o));

    p_code_legal_r9: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
        (cause_o != 5'd6 && cause_o <= 5'd18));

endmodule

bind boot_reset_gen rstgen_chk u_chk (
    .clk_i      (clk_i),
    .pwr_ok_i   (pwr_ok_i),
    .lvl_req_i  (lvl_req_i),
    .temp_err_i (temp_err_i),
    .pvdd_ok_i  (pvdd_ok_i),
    .ilim_ok_i  (ilim_ok_i),
    .rst_o      (rst_o),
    .cause_o    (cause_o)
);

// File: tb/boot_reset_gen_tb.sv
`timescale 1ns/1ps
module boot_reset_gen_tb;

    localparam int STRETCH = 4;

    logic        clk = 1'b0;
    logic        pwr_ok;
    logic [12:0] lvl;
    logic [1:0]  temp;
    logic        pvdd_ok;
    logic        ilim_ok;
    logic        rst;
    logic [4:0]  cause;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // model state
    int edge_idx = 0;
    int last_act = 0;
    bit exp_rst  = 1'b1;
    int exp_cause = 0;
    bit prev_t0 = 0, prev_t1 = 0;
    int lvl_map [13] = '{1, 2, 3, 4, 5, 7, 8, 9, 10, 11, 12, 17, 18}; // R4

    always #4 clk = ~clk;

    boot_reset_gen #(.STRETCH(STRETCH)) u_dut (
        .clk_i      (clk),
        .pwr_ok_i   (pwr_ok),
        .lvl_req_i  (lvl),
        .temp_err_i (temp),
        .pvdd_ok_i  (pvdd_ok),
        .ilim_ok_i  (ilim_ok),
        .rst_o      (rst),
        .cause_o    (cause)
    );

    // behavioural reference, evaluated on each rising edge
    always @(posedge clk) begin
        int best;
        bit act;
        edge_idx++;
        if (!pwr_ok) begin
            last_act  = edge_idx;
            exp_rst   = 1'b1;
            exp_cause = 0;
            prev_t0   = 0;
            prev_t1   = 0;
        end else begin
            best = 99;
            for (int i = 0; i < 13; i++)
                if (lvl[i] && lvl_map[i] < best) best = lvl_map[i];
            if (prev_t0 && !temp[0] && best > 13) best = 13;      // R5
            if (prev_t1 && !temp[1] && best > 14) best = 14;
            if (!pvdd_ok && best > 15) best = 15;                 // R6
            if (!ilim_ok && best > 16) best = 16;
            act = (best != 99);
            if (act) begin
                if (!exp_rst) exp_cause = best;                   // R7 R8
                last_act = edge_idx;
            end
            exp_rst = ((edge_idx - last_act) <= STRETCH);         // R2 R3
            prev_t0 = temp[0];
            prev_t1 = temp[1];
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (!done && edge_idx > 0) begin
            if (!pwr_ok) begin
                exp_rst   = 1'b1;
                exp_cause = 0;
            end
            n_cmp++;
            if (rst !== exp_rst) begin
                n_bad++;
                $display("FAIL R1 R2 R3 R5 R6 rst_o at edge %0d: got %0b expected %0b",
                         edge_idx, rst, exp_rst);
            end
            n_cmp++;
            if (cause !== 5'(exp_cause)) begin
                n_bad++;
                $display("FAIL R4 R7 R8 R9 R10 cause_o at edge %0d: got %0d expected %0d",
                         edge_idx, cause, exp_cause);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        pwr_ok = 1'b0; lvl = '0; temp = '0; pvdd_ok = 1'b1; ilim_ok = 1'b1;
        // R1: power-on hold and release with stretch (R3)
        step(3);
        pwr_ok = 1'b1;
        step(10);
        // R4: each level request alone, two cycles, then release (R2 R3)
        for (int i = 0; i < 13; i++) begin
            lvl[i] = 1'b1; step(2);
            lvl[i] = 1'b0; step(8);
        end
        // R5: rising edge and steady high do nothing, falling edge requests
        temp[0] = 1'b1; step(8);
        temp[0] = 1'b0; step(8);
        temp[1] = 1'b1; step(8);
        temp[1] = 1'b0; step(8);
        // R6: active-low supply flags
        pvdd_ok = 1'b0; step(3);
        pvdd_ok = 1'b1; step(8);
        ilim_ok = 1'b0; step(2);
        ilim_ok = 1'b1; step(8);
        // R7: simultaneous codes 7, 18 and 16: lowest wins
        lvl[5] = 1'b1; lvl[12] = 1'b1; ilim_ok = 1'b0; step(1);
        lvl = '0; ilim_ok = 1'b1; step(8);
        // R7: temp0 fall (13) against current limit (16)
        temp[0] = 1'b1; step(8);
        temp[0] = 1'b0; ilim_ok = 1'b0; step(1);
        ilim_ok = 1'b1; step(8);
        // R8: new request during stretch extends reset, cause kept at 10
        lvl[8] = 1'b1; step(1);
        lvl[8] = 1'b0; step(2);
        lvl[0] = 1'b1; step(1);
        lvl[0] = 1'b0; step(8);
        // R2: long hold
        lvl[3] = 1'b1; step(20);
        lvl[3] = 1'b0; step(8);
        // R10: power-on while another request is present gives code 0
        lvl[4] = 1'b1; step(2);
        pwr_ok = 1'b0; step(2);
        pwr_ok = 1'b1; step(2);
        lvl[4] = 1'b0; step(10);
        // R9: code never 6; covered by every cause comparison above
        lvl[6] = 1'b1; step(1);
        lvl[6] = 1'b0; step(8);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule